// File: doc/BRIEF.md
# Dual-Rail Precharge Mixing Datapath

This block computes an 8-bit (by default) bitwise mixing function in a dual-rail, return-to-zero style. Every logical bit inside the block is carried on a pair of wires, a true rail and a false rail. Only non-inverting AND and OR gate pairs are used, and logical negation is a swap of the two rails. A phase controller alternates the block between a precharge phase, in which every rail pair sits at 00, and an evaluation phase, in which every pair carries exactly one high rail. Because of this, the number of wires that switch at each phase edge does not depend on the data.

A single-rail operand pair is offered with `in_valid` while `in_ready` is high, which is during precharge. On the edge that enters evaluation, the operands are encoded onto the input rails. On the edge that leaves evaluation, a decoder samples the output rails and presents a single-rail result with a one-clock `out_valid` pulse. The result is `y[i] = (a[i] AND b[i]) XOR t[i]`, where `t[i] = NOT a[(i+ROT) mod W]` when `INV_TAP` is 1 and `a[(i+ROT) mod W]` when it is 0. The XOR is built from AND/OR pairs. All dual-rail nets are exported so that their switching can be observed.

Top module: `drpl_mix_core`

## Requirements
- R1: During evaluation, a logical 1 on a bit appears as true rail 1 and false rail 0, and a logical 0 appears as true rail 0 and false rail 1. The debug export places operand A rails in `dbg_t/dbg_f[W-1:0]` and operand B rails in `[2W-1:W]`.
- R2: In every precharge cycle, all 6*W true rails and all 6*W false rails of the debug export are 0.
- R3: In every evaluation cycle, each exported pair has exactly one rail high, and `out_err` stays 0.
- R4: After reset the block is in precharge. The phase then changes on every rising clock edge. `in_ready` is 1 exactly in precharge cycles.
- R5: At every clock edge after reset, exactly 6*W of the 12*W exported wires toggle, whatever the operands.
- R6: An operand pair accepted with `in_valid` and `in_ready` gives `out_valid` = 1 for exactly the one cycle after its evaluation cycle. `out_y` equals the function above with W=8, ROT=1, INV_TAP=1.
- R7: `in_valid` during an evaluation cycle is ignored. It produces no `out_valid`, and `out_y` keeps its last value.
- R8: In reset, `out_valid`, `out_y` and `out_err` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock; each rising edge switches phase |
| rst_n | input | 1 | asynchronous active-low reset |
| in_valid | input | 1 | operand pair offered |
| in_ready | output | 1 | high in precharge; operands are taken on the next edge |
| in_a | input | W | single-rail operand A |
| in_b | input | W | single-rail operand B |
| out_valid | output | 1 | one-cycle pulse with a new result |
| out_y | output | W | decoded single-rail result |
| out_err | output | 1 | an output pair read 00 or 11 at the end of evaluation |
| dbg_t | output | 6*W | true rails of all dual-rail nets |
| dbg_f | output | 6*W | false rails of all dual-rail nets |

## Verification
The bench targets operands that are all zeros, all ones, alternating bits, and single bits at the edges of the word, which lie at the extremes of data-dependent switching. A design that used a real inverter, or that left any net out of precharge, would show a nonzero pair in precharge and a toggle count that moves with the data. The bench also drives `in_valid` during evaluation and confirms that the request is dropped. A controller that sampled operands in both phases would emit an extra `out_valid` or change `out_y`. Randomly spaced requests with idle evaluations in between check that the result pulse follows only accepted operands.

// File: rtl/drpl_pkg.sv
package drpl_pkg;
   typedef enum logic {DR_AND = 1'b0, DR_OR = 1'b1} dr_gate_e;
   typedef enum logic {PH_PRE = 1'b0, PH_EVA = 1'b1} dr_phase_e;
   localparam int unsigned NET_GROUPS = 6;
endpackage

// File: rtl/drpl_gate.sv
module drpl_gate
   import drpl_pkg::*;
#(
   parameter int unsigned W    = 8,
   parameter dr_gate_e    KIND = DR_AND
) (
   input  logic [W-1:0] a_t,
   input  logic [W-1:0] a_f,
   input  logic [W-1:0] b_t,
   input  logic [W-1:0] b_f,
   output logic [W-1:0] y_t,
   output logic [W-1:0] y_f
);
   // positive-only pair: both rails monotone, so 00 inputs give 00 outputs
   if (KIND == DR_AND) begin : g_and
      assign y_t = a_t & b_t;
      assign y_f = a_f | b_f;
   end else begin : g_or
      assign y_t = a_t | b_t;
      assign y_f = a_f & b_f;
   end
endmodule

// File: rtl/drpl_xor.sv
module drpl_xor
   import drpl_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] p_t,
   input  logic [W-1:0] p_f,
   input  logic [W-1:0] q_t,
   input  logic [W-1:0] q_f,
   output logic [W-1:0] u1_t,
   output logic [W-1:0] u1_f,
   output logic [W-1:0] u2_t,
   output logic [W-1:0] u2_f,
   output logic [W-1:0] y_t,
   output logic [W-1:0] y_f
);
   // p AND (NOT q): negation of q is a rail swap
   drpl_gate #(.W(W), .KIND(DR_AND)) u_pnq (
      .a_t(p_t), .a_f(p_f), .b_t(q_f), .b_f(q_t), .y_t(u1_t), .y_f(u1_f));
   // (NOT p) AND q
   drpl_gate #(.W(W), .KIND(DR_AND)) u_npq (
      .a_t(p_f), .a_f(p_t), .b_t(q_t), .b_f(q_f), .y_t(u2_t), .y_f(u2_f));
   drpl_gate #(.W(W), .KIND(DR_OR)) u_join (
      .a_t(u1_t), .a_f(u1_f), .b_t(u2_t), .b_f(u2_f), .y_t(y_t), .y_f(y_f));
endmodule

// File: rtl/drpl_phase_ctl.sv
module drpl_phase_ctl
   import drpl_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid_i,
   input  logic [W-1:0] in_a_i,
   input  logic [W-1:0] in_b_i,
   output logic         eval_o,
   output logic         tag_o,
   output logic [W-1:0] a_t,
   output logic [W-1:0] a_f,
   output logic [W-1:0] b_t,
   output logic [W-1:0] b_f
);
   dr_phase_e    phase_q;
   logic [W-1:0] hold_a_q, hold_b_q;
   logic [W-1:0] next_a, next_b;

   assign eval_o = (phase_q == PH_EVA);
   assign next_a = in_valid_i ? in_a_i : hold_a_q;
   assign next_b = in_valid_i ? in_b_i : hold_b_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_PRE;
         tag_o    <= 1'b0;
         hold_a_q <= '0;
         hold_b_q <= '0;
         a_t <= '0; a_f <= '0; b_t <= '0; b_f <= '0;
      end else if (phase_q == PH_PRE) begin
         phase_q  <= PH_EVA;
         tag_o    <= in_valid_i;
         hold_a_q <= next_a;
         hold_b_q <= next_b;
         a_t <= next_a;  a_f <= ~next_a;
         b_t <= next_b;  b_f <= ~next_b;
      end else begin
         phase_q <= PH_PRE;
         tag_o   <= 1'b0;
         a_t <= '0; a_f <= '0; b_t <= '0; b_f <= '0;
      end
   end

   AST_PHASE_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (eval_o != $past(eval_o)));                      // R4
   AST_TAG_FROM_PRECHARGE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_o && tag_o) |-> $past(in_valid_i));                  // R7
endmodule

// File: rtl/drpl_decoder.sv
module drpl_decoder
   import drpl_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         eval_i,
   input  logic         tag_i,
   input  logic [W-1:0] y_t,
   input  logic [W-1:0] y_f,
   output logic         out_valid,
   output logic [W-1:0] out_y,
   output logic         out_err
);
   logic bad_pair;
   assign bad_pair = (|(y_t & y_f)) | (|(~(y_t | y_f)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_y     <= '0;
         out_err   <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         if (eval_i) begin
            out_valid <= tag_i;
            out_err   <= bad_pair;
            if (tag_i) out_y <= y_t;
         end
      end
   end

   AST_EVAL_WELLFORMED: assert property (@(posedge clk) disable iff (!rst_n)
      eval_i |-> (((y_t ^ y_f) == {W{1'b1}}) && ((y_t & y_f) == '0))); // R3
   AST_VALID_IN_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !eval_i);                                   // R6
endmodule

// File: rtl/drpl_mix_core.sv
module drpl_mix_core
   import drpl_pkg::*;
#(
   parameter int unsigned W       = 8,
   parameter int unsigned ROT     = 1,
   parameter bit          INV_TAP = 1'b1,
   localparam int unsigned DBG_W  = NET_GROUPS * W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [W-1:0]     in_a,
   input  logic [W-1:0]     in_b,
   output logic             out_valid,
   output logic [W-1:0]     out_y,
   output logic             out_err,
   output logic [DBG_W-1:0] dbg_t,
   output logic [DBG_W-1:0] dbg_f
);
   if (W < 2) begin : g_bad_width
      $error("drpl_mix_core: W must be at least 2");
   end
   if (ROT < 1 || ROT >= W) begin : g_bad_rot
      $error("drpl_mix_core: ROT must lie in 1..W-1");
   end

   logic         eval_q, tag_q;
   logic [W-1:0] a_t, a_f, b_t, b_f;
   logic [W-1:0] p_t, p_f, k_t, k_f;
   logic [W-1:0] u1_t, u1_f, u2_t, u2_f, y_t, y_f;

   drpl_phase_ctl #(.W(W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid),
      .in_a_i(in_a), .in_b_i(in_b),
      .eval_o(eval_q), .tag_o(tag_q),
      .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f));

   assign in_ready = !eval_q;

   drpl_gate #(.W(W), .KIND(DR_AND)) u_and (
      .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f), .y_t(p_t), .y_f(p_f));

   // rotated tap of operand A; optional negation by rail swap
   for (genvar i = 0; i < W; i++) begin : g_tap
      localparam int unsigned SRC = (i + ROT) % W;
      if (INV_TAP) begin : g_swap
         assign k_t[i] = a_f[SRC];
         assign k_f[i] = a_t[SRC];
      end else begin : g_keep
         assign k_t[i] = a_t[SRC];
         assign k_f[i] = a_f[SRC];
      end
   end

   drpl_xor #(.W(W)) u_xor (
      .p_t(p_t), .p_f(p_f), .q_t(k_t), .q_f(k_f),
      .u1_t(u1_t), .u1_f(u1_f), .u2_t(u2_t), .u2_f(u2_f),
      .y_t(y_t), .y_f(y_f));

   drpl_decoder #(.W(W)) u_dec (
      .clk(clk), .rst_n(rst_n), .eval_i(eval_q), .tag_i(tag_q),
      .y_t(y_t), .y_f(y_f),
      .out_valid(out_valid), .out_y(out_y), .out_err(out_err));

   assign dbg_t = {y_t, u2_t, u1_t, p_t, b_t, a_t};
   assign dbg_f = {y_f, u2_f, u1_f, p_f, b_f, a_f};

   AST_PRECHARGE_NETS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !eval_q |-> ((dbg_t == '0) && (dbg_f == '0)));            // R2
   AST_CONSTANT_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ($countones({dbg_t, dbg_f} ^ $past({dbg_t, dbg_f})) == DBG_W)); // R5
endmodule

// File: tb/tb_drpl_mix_core.sv
module tb_drpl_mix_core;
   localparam int unsigned W     = 8;
   localparam int unsigned ROT   = 1;
   localparam bit          INV   = 1'b1;
   localparam int unsigned DBG_W = 6 * W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic [W-1:0]     in_a = '0, in_b = '0;
   logic             in_ready, out_valid, out_err;
   logic [W-1:0]     out_y;
   logic [DBG_W-1:0] dbg_t, dbg_f;

   int checks = 0, fails = 0;
   bit mon_on = 1'b0;
   bit exp_eval = 1'b0;
   logic [2*DBG_W-1:0] prev_nets = '0;
   logic [W-1:0] last_y = '0;

   always #10 clk = ~clk;

   drpl_mix_core #(.W(W), .ROT(ROT), .INV_TAP(INV)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_y(out_y),
      .out_err(out_err), .dbg_t(dbg_t), .dbg_f(dbg_f));

   function automatic logic [W-1:0] ref_mix(input logic [W-1:0] a, input logic [W-1:0] b);
      logic [W-1:0] y;
      for (int i = 0; i < W; i++) begin
         logic t;
         t = a[(i + ROT) % W];
         if (INV) t = ~t;
         y[i] = (a[i] & b[i]) ^ t;
      end
      return y;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // phase-level monitor, sampled mid-high after each edge
   always @(posedge clk) begin
      #5;
      if (mon_on) begin
         int nt;
         exp_eval = !exp_eval;
         chk(in_ready == !exp_eval, "R4 in_ready vs phase", in_ready, !exp_eval);
         if (!exp_eval)
            chk(dbg_t == '0 && dbg_f == '0, "R2 precharge nets", {dbg_t, dbg_f}, 0);
         else
            chk(((dbg_t ^ dbg_f) == {DBG_W{1'b1}}) && ((dbg_t & dbg_f) == '0),
                "R3 one rail per pair", {dbg_t, dbg_f}, 0);
         nt = $countones({dbg_t, dbg_f} ^ prev_nets);
         chk(nt == DBG_W, "R5 toggle count", nt, DBG_W);
         if (exp_eval) chk(out_err == 1'b0, "R3 out_err", out_err, 0);
         prev_nets = {dbg_t, dbg_f};
      end
   end

   task automatic do_op(input logic [W-1:0] a, input logic [W-1:0] b);
      logic [W-1:0] e;
      e = ref_mix(a, b);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_a = a; in_b = b;
      @(negedge clk);                   // evaluation cycle
      in_valid = 1'b0;
      chk(dbg_t[W-1:0] == a && dbg_f[W-1:0] == ~a, "R1 operand A rails",
          {dbg_t[W-1:0], dbg_f[W-1:0]}, {a, ~a});
      chk(dbg_t[2*W-1:W] == b && dbg_f[2*W-1:W] == ~b, "R1 operand B rails",
          {dbg_t[2*W-1:W], dbg_f[2*W-1:W]}, {b, ~b});
      chk(out_valid == 1'b0, "R6 no valid during eval", out_valid, 0);
      @(negedge clk);                   // precharge after evaluation
      chk(out_valid == 1'b1, "R6 valid pulse", out_valid, 1);
      chk(out_y == e, "R6 result", out_y, e);
      chk(out_err == 1'b0, "R3 no decode error", out_err, 0);
      last_y = e;
   endtask

   task automatic eval_request_ignored(input logic [W-1:0] a);
      @(negedge clk);                   // evaluation (idle)
      chk(in_ready == 1'b0, "R7 in eval", in_ready, 0);
      in_valid = 1'b1; in_a = a; in_b = ~a;
      @(negedge clk);                   // precharge
      in_valid = 1'b0;
      chk(out_valid == 1'b0, "R7 no pulse from eval request", out_valid, 0);
      chk(out_y == last_y, "R7 result kept", out_y, last_y);
      @(negedge clk);
      @(negedge clk);
      chk(out_valid == 1'b0, "R7 still no pulse", out_valid, 0);
      chk(out_y == last_y, "R7 result still kept", out_y, last_y);
   endtask

   initial begin
      repeat (10000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [31:0] seed;
      seed = $urandom(32'h0d5a_17c3);
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0 && out_y == '0 && out_err == 1'b0, "R8 reset outputs",
          {out_valid, out_y, out_err}, 0);
      chk(in_ready == 1'b1, "R8 reset ready", in_ready, 1);
      chk(dbg_t == '0 && dbg_f == '0, "R8 reset nets", {dbg_t, dbg_f}, 0);
      rst_n = 1'b1;
      mon_on = 1'b1;

      do_op(8'h00, 8'h00);
      do_op(8'hFF, 8'hFF);
      do_op(8'hAA, 8'h55);
      do_op(8'h55, 8'hAA);
      do_op(8'h80, 8'h01);
      do_op(8'h01, 8'h80);
      eval_request_ignored(8'hC3);
      do_op(8'hF0, 8'h0F);
      eval_request_ignored(8'h3C);

      for (int n = 0; n < 300; n++) begin
         logic [W-1:0] ra, rb;
         ra = W'($urandom);
         rb = W'($urandom);
         do_op(ra, rb);
         repeat ($urandom_range(0, 3)) @(negedge clk);
      end

      repeat (4) @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule